// File: doc/BRIEF.md
# Triggered Hit-Latch Pipeline Register

This block takes a bank of single-bit discriminator hit lines and records their state on every edge of the beam-synchronous clock. Each sample goes into a circular delay store, one per group of channels. The store keeps the recent history until a first-level trigger decision arrives. A first-level trigger copies the sample taken a programmable number of clock edges earlier into a small event store. Each stored event is tagged with a running sequence number.

Events from a first-level trigger are only tentative. A second-level accept releases every tentative event for readout. A fast clear throws the tentative events away. If no second-level accept arrives within a fixed window after the latest capture, the tentative events are also thrown away. Released events leave through a readout port in FIFO order. A full flag warns the trigger logic, and a saturating counter records the first-level triggers that were lost because the store was full.

Top module: `hit_latch_pipe`

## Requirements
- R1: While `gate_i` is low, the block records an all-zero sample for that edge, whatever the state of `hit_i`.
- R2: A first-level trigger at clock edge n captures the gated `hit_i` sample recorded at edge n−D, where D is the current delay value and 1 ≤ D ≤ PIPE_DEPTH−1. Bit k of `rd_data_o` is hit line k. This holds once PIPE_DEPTH edges have passed since reset.
- R3: After reset the delay value is DLY_RST. A write (`cfg_we_i` high at an edge) loads `cfg_wdata_i`, and the new value is used from the next edge on.
- R4: A captured event is tentative and does not make `rd_valid_o` high. A second-level accept releases every tentative event captured before that edge.
- R5: A fast clear discards every tentative event, and a first-level trigger at the same edge is ignored and takes no sequence number. Events already released stay readable.
- R6: If L2_TIMEOUT edges pass after the most recent capture with neither an accept nor a clear, the tentative events are discarded. An accept at any earlier edge still releases them.
- R7: Released events are read in capture order. `rd_valid_o` high means `rd_data_o` and `rd_seq_o` show the oldest released event, and `rd_en_i` at an edge removes it. `rd_en_i` while `rd_valid_o` is low has no effect.
- R8: `rd_seq_o` is 0 for the first capture after reset and goes up by one for every capture, including captures that are later discarded.
- R9: `buf_full_o` is high when stored events (tentative plus released) equal EVT_DEPTH. A first-level trigger at such an edge stores nothing and adds one to `lost_cnt_o`, which saturates.
- R10: After reset `rd_valid_o`, `buf_full_o` and `lost_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-synchronous sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | HIT_W | Discriminator hit lines |
| gate_i | input | 1 | Sampling window; zeros are recorded when low |
| l1_trig_i | input | 1 | First-level trigger strobe |
| l2_accept_i | input | 1 | Second-level accept strobe |
| fast_clear_i | input | 1 | Discard tentative events |
| cfg_we_i | input | 1 | Delay register write strobe |
| cfg_wdata_i | input | DLY_W | New delay value |
| rd_en_i | input | 1 | Remove the oldest released event |
| rd_valid_o | output | 1 | A released event is available |
| rd_data_o | output | HIT_W | Hit pattern of the oldest released event |
| rd_seq_o | output | SEQ_W | Sequence tag of the oldest released event |
| buf_full_o | output | 1 | No event slot remains |
| lost_cnt_o | output | LOST_W | Saturating count of lost first-level triggers |

## Verification
The assertions assume that every strobe is a clean synchronous level, sampled once per edge. They also assume a delay value of at least 1, and that no capture check is made before the delay store has been filled once since reset. The stimulus changes inputs only on the falling edge. It runs more than PIPE_DEPTH idle edges with the gate low before the first capture, so the store holds known zeros. It programs only delays inside the legal range. Accepts are placed deliberately just inside and well outside the timeout window, so that neither case sits on the exact boundary edge.

// File: rtl/hlp_pkg.sv
package hlp_pkg;

    // What happens to the tentative events at one clock edge
    typedef enum logic [1:0] {
        PEND_HOLD,
        PEND_RELEASE,
        PEND_DROP
    } pend_act_e;

endpackage

// File: rtl/hlp_delay_reg.sv
module hlp_delay_reg #(
    parameter int DW      = 10,
    parameter int RST_VAL = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] delay_o
);

    logic [DW-1:0] dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (we_i) dly_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= DW'(RST_VAL);
        else        dly_q <= dly_d;
    end

    assign delay_o = dly_q;

    // R3: a write is visible on the following edge
    a_r3_delay_load: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> dly_q == $past(wdata_i));

endmodule

// File: rtl/hlp_delay_bank.sv
module hlp_delay_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        mem_q[wr_addr_i] <= wr_data_i;
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/hlp_event_store.sv
module hlp_event_store
    import hlp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SEQ_W   = 16,
    parameter int DEPTH   = 2048,
    parameter int LOST_W  = 16,
    parameter int TIMEOUT = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int TW     = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_i,
    input  logic              l2_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_en_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [SEQ_W-1:0]  rd_seq_o,
    output logic              full_o,
    output logic [LOST_W-1:0] lost_o
);

    typedef struct packed {
        logic [AW:0]       wr;
        logic [AW:0]       rel;
        logic [AW:0]       rd;
        logic [TW-1:0]     tmr;
        logic [SEQ_W-1:0]  seq;
        logic [LOST_W-1:0] lost;
    } st_t;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
    } entry_t;

    st_t       st_d, st_q;
    entry_t    mem_q [DEPTH];
    logic [AW:0] used;
    logic      full, pending, avail, capture, lost_hit;
    pend_act_e act;

    always_comb begin
        st_d     = st_q;
        used     = st_q.wr - st_q.rd;
        full     = (used == (AW+1)'(DEPTH));
        pending  = (st_q.wr != st_q.rel);
        avail    = (st_q.rel != st_q.rd);
        capture  = l1_i && !clear_i && !full;
        lost_hit = l1_i && !clear_i && full;

        if (clear_i)
            act = PEND_DROP;
        else if (l2_i)
            act = PEND_RELEASE;
        else if (pending && !capture && st_q.tmr == TW'(TIMEOUT - 1))
            act = PEND_DROP;
        else
            act = PEND_HOLD;

        case (act)
            PEND_RELEASE: st_d.rel = st_q.wr;
            PEND_DROP:    st_d.wr  = st_q.rel;
            default:      ;
        endcase

        if (capture) begin
            st_d.wr  = st_q.wr + 1'b1;
            st_d.seq = st_q.seq + 1'b1;
        end

        if (lost_hit && st_q.lost != '1)
            st_d.lost = st_q.lost + 1'b1;

        if (capture || act != PEND_HOLD || !pending)
            st_d.tmr = '0;
        else
            st_d.tmr = st_q.tmr + 1'b1;

        if (rd_en_i && avail)
            st_d.rd = st_q.rd + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (capture) mem_q[st_q.wr[AW-1:0]] <= '{seq: st_q.seq, data: data_i};
    end

    assign rd_valid_o = avail;
    assign rd_data_o  = mem_q[st_q.rd[AW-1:0]].data;
    assign rd_seq_o   = mem_q[st_q.rd[AW-1:0]].seq;
    assign full_o     = full;
    assign lost_o     = st_q.lost;

    // R9: occupancy never exceeds the store size
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr - st_q.rd) <= (AW+1)'(DEPTH));

    // R9: a trigger while full bumps the lost counter
    a_r9_lost_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_i && !clear_i && full && st_q.lost != '1) |=> st_q.lost == $past(st_q.lost) + 1'b1);

    // R5: after a fast clear nothing is tentative
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> st_q.wr == st_q.rel);

    // R7: reading an empty released queue leaves it alone
    a_r7_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && st_q.rel == st_q.rd) |=> st_q.rd == $past(st_q.rd));

    // R8: each capture takes the next sequence number
    a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_i && !clear_i && !full) |=> st_q.seq == $past(st_q.seq) + 1'b1);

    // R6: the second-level window counter stays inside the window
    a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr < TW'(TIMEOUT));

endmodule

// File: rtl/hit_latch_pipe.sv
module hit_latch_pipe #(
    parameter int BANK_W     = 16,
    parameter int NUM_BANKS  = 2,
    parameter int PIPE_DEPTH = 1024,
    parameter int EVT_DEPTH  = 2048,
    parameter int SEQ_W      = 16,
    parameter int LOST_W     = 16,
    parameter int L2_TIMEOUT = 8,
    parameter int DLY_RST    = 16,
    localparam int HIT_W     = BANK_W * NUM_BANKS,
    localparam int DLY_W     = $clog2(PIPE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIT_W-1:0]  hit_i,
    input  logic              gate_i,
    input  logic              l1_trig_i,
    input  logic              l2_accept_i,
    input  logic              fast_clear_i,
    input  logic              cfg_we_i,
    input  logic [DLY_W-1:0]  cfg_wdata_i,
    input  logic              rd_en_i,
    output logic              rd_valid_o,
    output logic [HIT_W-1:0]  rd_data_o,
    output logic [SEQ_W-1:0]  rd_seq_o,
    output logic              buf_full_o,
    output logic [LOST_W-1:0] lost_cnt_o
);

    typedef struct packed {
        logic [DLY_W-1:0] wp;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [DLY_W-1:0] delay;
    logic [DLY_W-1:0] tap_addr;
    logic [HIT_W-1:0] sample;
    logic [HIT_W-1:0] tapped;

    hlp_delay_reg #(
        .DW      (DLY_W),
        .RST_VAL (DLY_RST)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .delay_o (delay)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wp  = st_q.wp + 1'b1;
        sample   = gate_i ? hit_i : '0;
        tap_addr = st_q.wp - delay;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        hlp_delay_bank #(
            .W     (BANK_W),
            .DEPTH (PIPE_DEPTH)
        ) u_bank (
            .clk       (clk),
            .wr_addr_i (st_q.wp),
            .wr_data_i (sample[g*BANK_W +: BANK_W]),
            .rd_addr_i (tap_addr),
            .rd_data_o (tapped[g*BANK_W +: BANK_W])
        );
    end

    hlp_event_store #(
        .DATA_W  (HIT_W),
        .SEQ_W   (SEQ_W),
        .DEPTH   (EVT_DEPTH),
        .LOST_W  (LOST_W),
        .TIMEOUT (L2_TIMEOUT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .l1_i       (l1_trig_i),
        .l2_i       (l2_accept_i),
        .clear_i    (fast_clear_i),
        .data_i     (tapped),
        .rd_en_i    (rd_en_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .rd_seq_o   (rd_seq_o),
        .full_o     (buf_full_o),
        .lost_o     (lost_cnt_o)
    );

    // R2: the write position moves by one slot on every edge
    a_r2_wp_walks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.wp == $past(st_q.wp) + 1'b1);

endmodule

// File: tb/hit_latch_pipe_test.sv
module hit_latch_pipe_test;

    localparam int PD  = 64;
    localparam int ED  = 8;
    localparam int TO  = 8;
    localparam int DR  = 3;
    localparam int DW  = $clog2(PD);

    logic          clk = 0;
    logic          rst_n;
    logic [31:0]   hit_i;
    logic          gate_i, l1_trig_i, l2_accept_i, fast_clear_i, cfg_we_i, rd_en_i;
    logic [DW-1:0] cfg_wdata_i;
    logic          rd_valid_o, buf_full_o;
    logic [31:0]   rd_data_o;
    logic [15:0]   rd_seq_o, lost_cnt_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_seq = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hit_latch_pipe #(
        .PIPE_DEPTH (PD),
        .EVT_DEPTH  (ED),
        .L2_TIMEOUT (TO),
        .DLY_RST    (DR)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit_i),
        .gate_i       (gate_i),
        .l1_trig_i    (l1_trig_i),
        .l2_accept_i  (l2_accept_i),
        .fast_clear_i (fast_clear_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .rd_en_i      (rd_en_i),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .rd_seq_o     (rd_seq_o),
        .buf_full_o   (buf_full_o),
        .lost_cnt_o   (lost_cnt_o)
    );

    function automatic logic [31:0] pat(input int i);
        return {16'(i * 37 + 5), 16'(~i)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [31:0] h, input logic g, input logic l1,
                       input logic l2, input logic fc, input logic rd);
        hit_i = h; gate_i = g; l1_trig_i = l1;
        l2_accept_i = l2; fast_clear_i = fc; rd_en_i = rd;
        @(posedge clk);
        @(negedge clk);
        hit_i = '0; gate_i = 0; l1_trig_i = 0;
        l2_accept_i = 0; fast_clear_i = 0; rd_en_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(32'h0, 0, 0, 0, 0, 0);
    endtask

    task automatic set_delay(input int d);
        cfg_we_i = 1; cfg_wdata_i = DW'(d);
        cyc(32'h0, 0, 0, 0, 0, 0);
        cfg_we_i = 0;
    endtask

    task automatic pop_check(input string req, input int seq, input logic [31:0] data, input bit use_data);
        chk({req, " valid"}, 64'(rd_valid_o), 64'd1);
        chk({req, " seq"}, 64'(rd_seq_o), 64'(16'(seq)));
        if (use_data) chk({req, " data"}, 64'(rd_data_o), 64'(data));
        cyc(32'h0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_reset;
        chk("R10 valid", 64'(rd_valid_o), 64'd0);
        chk("R10 full", 64'(buf_full_o), 64'd0);
        chk("R10 lost", 64'(lost_cnt_o), 64'd0);
    endtask

    // R3 reset delay value, R2 tap
    task automatic t_default_delay;
        for (int i = 200; i < 210; i++) cyc(pat(i), 1, i == 209, 0, 0, 0);
        exp_seq++;
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R3 reset delay", 0, pat(206), 1);
    endtask

    // R1: gate low records zeros
    task automatic t_gate;
        set_delay(5);
        for (int i = 0; i < 10; i++) cyc(32'hFFFF_FFFF, 0, i == 9, 0, 0, 0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R1 gated zero", exp_seq, 32'h0, 1);
        exp_seq++;
        chk("R1 empty after pop", 64'(rd_valid_o), 64'd0);
    endtask

    // R2 tap, R3 rewrite, R4 tentative, R7 order
    task automatic t_delay;
        for (int i = 0; i < 12; i++) cyc(pat(i), 1, i == 11, 0, 0, 0);
        chk("R4 tentative hidden", 64'(rd_valid_o), 64'd0);
        set_delay(1);
        for (int i = 100; i < 104; i++) cyc(pat(i), 1, i == 103, 0, 0, 0);
        chk("R4 still hidden", 64'(rd_valid_o), 64'd0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R2 delay 5", exp_seq, pat(6), 1);
        pop_check("R7 second in order", exp_seq + 1, pat(102), 1);
        exp_seq += 2;
        chk("R7 drained", 64'(rd_valid_o), 64'd0);
    endtask

    // R5 fast clear
    task automatic t_clear;
        cyc(32'h0, 0, 1, 0, 0, 0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        cyc(32'h0, 0, 1, 0, 0, 0);
        cyc(32'h0, 0, 1, 0, 0, 0);
        cyc(32'h0, 0, 1, 0, 1, 0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R5 released survives", exp_seq, 32'h0, 0);
        chk("R5 tentative discarded", 64'(rd_valid_o), 64'd0);
        exp_seq += 3;
        cyc(32'h0, 0, 1, 0, 0, 0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R5 trigger with clear ignored", exp_seq, 32'h0, 0);
        exp_seq++;
    endtask

    // R6 timeout, R8 discarded captures keep their numbers
    task automatic t_timeout;
        cyc(32'h0, 0, 1, 0, 0, 0);
        idle(TO - 2);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R6 accept in window", exp_seq, 32'h0, 0);
        exp_seq++;
        cyc(32'h0, 0, 1, 0, 0, 0);
        idle(TO);
        cyc(32'h0, 0, 0, 1, 0, 0);
        chk("R6 late accept finds nothing", 64'(rd_valid_o), 64'd0);
        exp_seq++;
        cyc(32'h0, 0, 1, 0, 0, 0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R8 seq skips discarded", exp_seq, 32'h0, 0);
        exp_seq++;
    endtask

    // R7 read while empty
    task automatic t_empty_read;
        cyc(32'h0, 0, 0, 0, 0, 1);
        chk("R7 empty read no effect", 64'(rd_valid_o), 64'd0);
        cyc(32'h0, 0, 1, 0, 0, 0);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R7 after empty read", exp_seq, 32'h0, 0);
        exp_seq++;
        chk("R7 single entry", 64'(rd_valid_o), 64'd0);
    endtask

    // R9 full and lost triggers
    task automatic t_full;
        for (int i = 0; i < ED; i++) cyc(32'h0, 0, 1, 0, 0, 0);
        chk("R9 full", 64'(buf_full_o), 64'd1);
        cyc(32'h0, 0, 1, 0, 0, 0);
        chk("R9 lost count", 64'(lost_cnt_o), 64'd1);
        chk("R9 still full", 64'(buf_full_o), 64'd1);
        cyc(32'h0, 0, 0, 1, 0, 0);
        pop_check("R9 first", exp_seq, 32'h0, 0);
        chk("R9 not full after pop", 64'(buf_full_o), 64'd0);
        for (int i = 1; i < ED; i++) pop_check("R9 drain", exp_seq + i, 32'h0, 0);
        chk("R9 lost trigger not stored", 64'(rd_valid_o), 64'd0);
        exp_seq += ED;
    endtask

    initial begin
        rst_n = 0; hit_i = '0; gate_i = 0; l1_trig_i = 0; l2_accept_i = 0;
        fast_clear_i = 0; cfg_we_i = 0; cfg_wdata_i = '0; rd_en_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        idle(PD + 6);
        t_default_delay;
        t_gate;
        t_delay;
        t_clear;
        t_timeout;
        t_empty_read;
        t_full;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule